// File: doc/BRIEF.md
# Rank Command Decoder with Per-Bank Open-Row Tracking

This block sits at the command input of one rank of an eight-bank SDRAM. On every clock edge it samples an active-low rank select, a 3-bit command code, a 3-bit bank number and a 14-bit address. When the rank is selected, it decodes four operations: open a row, read, write and close. It keeps an open/closed flag and the open row number for each bank. For each command it presents the decoded fields on registered outputs. When a command breaks the open/close discipline, it raises a one-cycle protocol-error pulse.

A controller model or a device model places the block ahead of its storage and data path. A legal command produces a one-cycle `outValid` pulse together with the command, the bank, the row, the starting column, a burst-chop flag and an all-banks flag. A close with the all-banks bit set resets the state of every bank in a single edge. Refresh, mode registers and data transfer are outside this block.

Top module: `rank_cmd_front`

## Requirements
- R1: While `csN` is high at a sampling edge, the command is ignored: on the next cycle `outValid` and `protoErr` are low and `bankOpen` is unchanged.
- R2: Command codes are NOP=3'b000, ACTIVATE=3'b001, READ=3'b010, WRITE=3'b011, PRECHARGE=3'b100. NOP and the unused codes 3'b101 to 3'b111 change no bank state and raise neither `outValid` nor `protoErr`.
- R3: An ACTIVATE to a closed bank sets that bank's bit in `bankOpen` and stores `addr[13:0]` as its open row. The cycle after sampling, `outValid` is high with `outCmd`=3'b001, `outBank`=`bankSel` and `outRow`=`addr`.
- R4: A READ or WRITE to an open bank gives, the cycle after sampling, `outValid` high, `outCmd` equal to the code, `outBank`, `outCol`=`addr[9:0]`, `outChop`=`addr[12]` and `outRow` equal to that bank's stored open row.
- R5: A PRECHARGE with `addr[10]`=0 closes only bank `bankSel`. With `addr[10]`=1 it closes all eight banks in the same edge and sets `outAllBanks`. Either form is reported with `outValid`, `outCmd`=3'b100 and `outBank`=`bankSel`.
- R6: An ACTIVATE to a bank that is already open raises `protoErr` for one cycle with `outValid` low. The bank stays open and keeps its previous row.
- R7: A READ or WRITE to a closed bank raises `protoErr` for one cycle with `outValid` low. No state changes.
- R8: A single-bank PRECHARGE to a bank that is already closed is legal. It is reported with `outValid` and no error, and `bankOpen` does not change.
- R9: During and after reset all banks are closed and all outputs are zero. Whenever `outValid` is low, `outCmd`, `outBank`, `outRow`, `outCol`, `outChop` and `outAllBanks` are zero, and `outValid` and `protoErr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low rank select; high masks the decoder |
| cmdCode | input | 3 | Command code (see R2) |
| bankSel | input | 3 | Bank number |
| addr | input | 14 | Row on ACTIVATE; column, chop and all-banks bits otherwise |
| outValid | output | 1 | One-cycle pulse for an accepted command |
| outCmd | output | 3 | Code of the accepted command |
| outBank | output | 3 | Bank of the accepted command |
| outRow | output | 14 | Row opened, or open row being accessed |
| outCol | output | 10 | Starting column for READ/WRITE |
| outChop | output | 1 | Burst-chop request for READ/WRITE |
| outAllBanks | output | 1 | PRECHARGE applied to all banks |
| protoErr | output | 1 | One-cycle pulse for an illegal sequence |
| bankOpen | output | 8 | Per-bank open flag, bit i for bank i |

## Verification
Every result is due exactly one cycle after the edge that samples the command, because the decoded fields, the error pulse and the bank flags all come from a single register stage. The driver applies a command at the falling edge and places the expected outputs and bank flags in a queue. The monitor removes one entry shortly after the next rising edge and compares it, so every expectation is checked in the cycle the design should produce it. Ignored commands are checked through the same queue, which confirms the quiet outputs and the unchanged `bankOpen` one cycle later.

// File: rtl/rank_cmd_pkg.sv
package rank_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'b000,
    CMD_ACT = 3'b001,
    CMD_RD  = 3'b010,
    CMD_WR  = 3'b011,
    CMD_PRE = 3'b100
  } cmd_e;

  // Strobes from the control decoder to the bank-state datapath
  typedef struct packed {
    logic openOne;
    logic closeOne;
    logic closeAll;
    logic accept;
    logic flagErr;
  } strobe_t;
endpackage

// File: rtl/rank_cmd_ctrl.sv
module rank_cmd_ctrl
  import rank_cmd_pkg::*;
#(
  parameter int BANK_W = 3,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                 csN,
  input  logic [2:0]           cmdCode,
  input  logic [BANK_W-1:0]    bankSel,
  input  logic                 allSel,
  input  logic [NUM_BANKS-1:0] bankOpen,
  output strobe_t              stb
);
  logic targetOpen;
  assign targetOpen = bankOpen[bankSel];

  always_comb begin
    stb = '0;
    if (!csN) begin
      case (cmdCode)
        CMD_ACT: begin
          if (targetOpen) stb.flagErr = 1'b1;
          else begin
            stb.openOne = 1'b1;
            stb.accept  = 1'b1;
          end
        end
        CMD_RD, CMD_WR: begin
          if (targetOpen) stb.accept = 1'b1;
          else stb.flagErr = 1'b1;
        end
        CMD_PRE: begin
          stb.accept   = 1'b1;
          stb.closeAll = allSel;
          stb.closeOne = !allSel;
        end
        default: stb = '0;
      endcase
    end
  end
endmodule

// File: rtl/rank_bank_state.sv
module rank_bank_state
  import rank_cmd_pkg::*;
#(
  parameter int BANK_W   = 3,
  parameter int ADDR_W   = 14,
  parameter int ROW_W    = 14,
  parameter int COL_W    = 10,
  parameter int CHOP_BIT = 12,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [2:0]           cmdCode,
  input  logic [BANK_W-1:0]    bankSel,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 allSel,
  output logic                 outValid,
  output logic [2:0]           outCmd,
  output logic [BANK_W-1:0]    outBank,
  output logic [ROW_W-1:0]     outRow,
  output logic [COL_W-1:0]     outCol,
  output logic                 outChop,
  output logic                 outAllBanks,
  output logic                 protoErr,
  output logic [NUM_BANKS-1:0] bankOpen
);
  logic [ROW_W-1:0] rowQ [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hitThis;
    assign hitThis = (bankSel == BANK_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankOpen[g] <= 1'b0;
        rowQ[g]     <= '0;
      end else if (stb.openOne && hitThis) begin
        bankOpen[g] <= 1'b1;
        rowQ[g]     <= addr[ROW_W-1:0];
      end else if (stb.closeAll || (stb.closeOne && hitThis)) begin
        bankOpen[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    outValid    <= 1'b0;
    outCmd      <= '0;
    outBank     <= '0;
    outRow      <= '0;
    outCol      <= '0;
    outChop     <= 1'b0;
    outAllBanks <= 1'b0;
    protoErr    <= 1'b0;
    if (rstN) begin
      protoErr <= stb.flagErr;
      if (stb.accept) begin
        outValid <= 1'b1;
        outCmd   <= cmdCode;
        outBank  <= bankSel;
        case (cmdCode)
          CMD_ACT: outRow <= addr[ROW_W-1:0];
          CMD_RD, CMD_WR: begin
            outRow  <= rowQ[bankSel];
            outCol  <= addr[COL_W-1:0];
            outChop <= addr[CHOP_BIT];
          end
          CMD_PRE: outAllBanks <= allSel;
          default: outRow <= '0;
        endcase
      end
    end
  end

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && protoErr)); // R9
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCmd == CMD_ACT) |-> bankOpen[outBank]); // R3
  AST_ACCESS_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (outCmd == CMD_RD || outCmd == CMD_WR)) |-> bankOpen[outBank]); // R4
  AST_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outAllBanks) |-> (bankOpen == '0)); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outRow == '0 && outCol == '0 && !outChop && !outAllBanks)); // R9
endmodule

// File: rtl/rank_cmd_front.sv
module rank_cmd_front
  import rank_cmd_pkg::*;
#(
  parameter int BANK_W   = 3,
  parameter int ADDR_W   = 14,
  parameter int ROW_W    = 14,
  parameter int COL_W    = 10,
  parameter int CHOP_BIT = 12,
  parameter int ALL_BIT  = 10,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic [2:0]           cmdCode,
  input  logic [BANK_W-1:0]    bankSel,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 outValid,
  output logic [2:0]           outCmd,
  output logic [BANK_W-1:0]    outBank,
  output logic [ROW_W-1:0]     outRow,
  output logic [COL_W-1:0]     outCol,
  output logic                 outChop,
  output logic                 outAllBanks,
  output logic                 protoErr,
  output logic [NUM_BANKS-1:0] bankOpen
);
  strobe_t stb;
  logic    allSel;
  assign allSel = addr[ALL_BIT];

  rank_cmd_ctrl #(.BANK_W(BANK_W)) u_ctrl (
    .csN(csN), .cmdCode(cmdCode), .bankSel(bankSel),
    .allSel(allSel), .bankOpen(bankOpen), .stb(stb)
  );

  rank_bank_state #(
    .BANK_W(BANK_W), .ADDR_W(ADDR_W), .ROW_W(ROW_W),
    .COL_W(COL_W), .CHOP_BIT(CHOP_BIT)
  ) u_state (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdCode(cmdCode),
    .bankSel(bankSel), .addr(addr), .allSel(allSel),
    .outValid(outValid), .outCmd(outCmd), .outBank(outBank),
    .outRow(outRow), .outCol(outCol), .outChop(outChop),
    .outAllBanks(outAllBanks), .protoErr(protoErr), .bankOpen(bankOpen)
  );

  AST_CS_MASKS: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (!outValid && !protoErr && $stable(bankOpen))); // R1
endmodule

// File: tb/rank_cmd_front_bench.sv
module rank_cmd_front_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic [2:0] cmdCode = '0;
  logic [2:0] bankSel = '0;
  logic [13:0] addr = '0;
  logic outValid, outChop, outAllBanks, protoErr;
  logic [2:0] outCmd, outBank;
  logic [13:0] outRow;
  logic [9:0] outCol;
  logic [7:0] bankOpen;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic v, e, ch, al;
    logic [2:0] c, b;
    logic [13:0] r;
    logic [9:0] col;
    logic [7:0] open;
    string tag;
  } exp_t;
  exp_t expQ[$];

  logic [7:0] mOpen = '0;
  logic [13:0] mRow [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  rank_cmd_front u_rank_cmd_front (
    .clk(clk), .rstN(rstN), .csN(csN), .cmdCode(cmdCode), .bankSel(bankSel),
    .addr(addr), .outValid(outValid), .outCmd(outCmd), .outBank(outBank),
    .outRow(outRow), .outCol(outCol), .outChop(outChop),
    .outAllBanks(outAllBanks), .protoErr(protoErr), .bankOpen(bankOpen)
  );

  task automatic issue(input logic csHigh, input logic [2:0] c,
                       input logic [2:0] b, input logic [13:0] a, input string tag);
    exp_t e;
    e.v = 0; e.e = 0; e.ch = 0; e.al = 0; e.c = 0; e.b = 0; e.r = 0; e.col = 0;
    e.tag = tag;
    if (!csHigh) begin
      case (c)
        3'b001: if (mOpen[b]) e.e = 1;
                else begin mOpen[b] = 1; mRow[b] = a; e.v = 1; e.c = c; e.b = b; e.r = a; end
        3'b010, 3'b011: if (!mOpen[b]) e.e = 1;
                else begin e.v = 1; e.c = c; e.b = b; e.r = mRow[b]; e.col = a[9:0]; e.ch = a[12]; end
        3'b100: begin
          e.v = 1; e.c = c; e.b = b; e.al = a[10];
          if (a[10]) mOpen = '0; else mOpen[b] = 0;
        end
        default: ;
      endcase
    end
    e.open = mOpen;
    @(negedge clk);
    csN = csHigh; cmdCode = c; bankSel = b; addr = a;
    expQ.push_back(e);
  endtask

  initial begin : monitor
    exp_t w;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        w = expQ.pop_front();
        checks++;
        if (outValid !== w.v || protoErr !== w.e || outCmd !== w.c || outBank !== w.b ||
            outRow !== w.r || outCol !== w.col || outChop !== w.ch ||
            outAllBanks !== w.al || bankOpen !== w.open) begin
          failures++;
          $display("FAIL %s: got v=%0b e=%0b cmd=%0d bank=%0d row=%h col=%h chop=%0b all=%0b open=%b; expected v=%0b e=%0b cmd=%0d bank=%0d row=%h col=%h chop=%0b all=%0b open=%b",
                   w.tag, outValid, protoErr, outCmd, outBank, outRow, outCol, outChop,
                   outAllBanks, bankOpen, w.v, w.e, w.c, w.b, w.r, w.col, w.ch, w.al, w.open);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    // R9: reset state, sampled while reset is still applied
    checks++;
    if (outValid !== 0 || protoErr !== 0 || bankOpen !== 8'h00 || outRow !== 0) begin
      failures++;
      $display("FAIL R9: got v=%0b e=%0b open=%b row=%h, expected all zero",
               outValid, protoErr, bankOpen, outRow);
    end
    rstN = 1'b1;
    issue(1, 3'b000, 3'd0, 14'h0000, "R9");
    // R1: rank not selected
    issue(1, 3'b001, 3'd2, 14'h1234, "R1");
    // R2: NOP and unused codes
    issue(0, 3'b000, 3'd2, 14'h1234, "R2");
    issue(0, 3'b101, 3'd2, 14'h0400, "R2");
    issue(0, 3'b110, 3'd3, 14'h3FFF, "R2");
    issue(0, 3'b111, 3'd4, 14'h0001, "R2");
    // R3: open rows
    issue(0, 3'b001, 3'd2, 14'h1234, "R3");
    issue(0, 3'b001, 3'd7, 14'h3FFF, "R3");
    issue(0, 3'b001, 3'd0, 14'h0000, "R3");
    // R4: accesses to open banks
    issue(0, 3'b010, 3'd2, 14'h13FF, "R4");
    issue(0, 3'b011, 3'd7, 14'h0005, "R4");
    issue(0, 3'b010, 3'd0, 14'h2C00, "R4");
    issue(1, 3'b010, 3'd2, 14'h0001, "R1");
    // R6: reopen an open bank
    issue(0, 3'b001, 3'd2, 14'h0001, "R6");
    issue(0, 3'b010, 3'd2, 14'h0003, "R6");
    // R7: access to closed bank
    issue(0, 3'b010, 3'd3, 14'h0010, "R7");
    issue(0, 3'b011, 3'd3, 14'h1010, "R7");
    // R8: close an already closed bank
    issue(0, 3'b100, 3'd5, 14'h0000, "R8");
    // R5: single bank then all banks
    issue(0, 3'b100, 3'd2, 14'h0000, "R5");
    issue(0, 3'b011, 3'd7, 14'h0100, "R5");
    issue(0, 3'b100, 3'd1, 14'h0400, "R5");
    issue(0, 3'b010, 3'd7, 14'h0000, "R7");
    // Back-to-back open of every bank, then full close
    for (int i = 0; i < 8; i++) issue(0, 3'b001, 3'(i), 14'(i * 14'h0811), "R3");
    for (int i = 0; i < 8; i++) issue(0, 3'b010, 3'(i), 14'(i * 14'h0041), "R4");
    issue(1, 3'b100, 3'd0, 14'h0400, "R1");
    issue(0, 3'b100, 3'd6, 14'h3BFF, "R5");
    issue(0, 3'b100, 3'd6, 14'h0400, "R5");
    issue(0, 3'b001, 3'd6, 14'h2AAA, "R3");
    issue(0, 3'b000, 3'd0, 14'h0000, "R2");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule